// File: doc/BRIEF.md
# Keyed Phase Front End for a Digital Synthesizer

This block sits between a control bus and the amplitude lookup stage of a direct digital synthesizer. It holds two frequency tuning words and four phase offsets. Software loads all six through a small address/data write port before transmission starts. After that, the modulating data drives only two select inputs.

The frequency select picks which tuning word the phase accumulator adds on each clock. Toggling it between a mark word and a space word gives binary frequency-shift keying. The accumulator is never cleared on a hop, so the carrier phase stays continuous. The phase select picks one of four offsets, which is added to the top bits of the accumulator. Two offsets of 0 and 180 degrees give binary phase keying. Four offsets of 0, +90, -90 and 180 degrees give quadrature phase keying, with two bits per symbol. The offset never alters the accumulator, so phase keying leaves the carrier frequency unchanged.

The output is the modulated phase word, and a separate stage converts it to amplitude. Reset puts the accumulator at phase zero. Several units on one clock that are reset together therefore stay coherent.

Top module: `dds_keying_mod`

## Requirements
- R1: While `rst` is sampled high, the accumulator, all six registers and both registered selects are cleared. `phase_out` reads 0 in the cycle after a reset edge.
- R2: A write with `wr_en` high is decoded from `wr_addr`. Addresses 0 and 1 load frequency words 0 and 1 with the full 28-bit `wr_data`. Addresses 2, 3, 4 and 5 load phase offsets 0 to 3 with `wr_data[11:0]`. The new value is in place at the clock edge that samples the write.
- R3: A write to address 6 or 7 changes no register and has no effect on `phase_out`.
- R4: On every clock edge out of reset, the 28-bit accumulator adds the frequency word chosen by the registered frequency select, modulo 2^28.
- R5: `fsel` is registered once. A change on `fsel` loads the registered select at the next edge, and the new word is first added at the edge after that.
- R6: Changing the frequency select never clears or reloads the accumulator. Phase continues from its current value.
- R7: `phase_out` equals accumulator bits [27:16] plus the offset chosen by the registered phase select, modulo 4096. It is combinational from those two registers. A change on `psel` is therefore visible right after the next edge.
- R8: A write to the frequency word that is currently selected is used in the addition at the edge after the write.
- R9: The phase select has no effect on the accumulator. With offsets 0x000, 0x400, 0xC00 and 0x800, the output is shifted by 0, +90, -90 and 180 degrees of a 4096-step circle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0-1 frequency, 2-5 phase |
| wr_data | input | 28 | Write data; phase registers take bits [11:0] |
| fsel | input | 1 | Frequency word select (mark/space) |
| psel | input | 2 | Phase offset select |
| phase_out | output | 12 | Modulated phase word for the amplitude stage |

## Verification
The design's results fall due on a fixed schedule:
- A register write is stored at the edge that samples it.
- An `fsel` change alters the accumulator step two edges later.
- A `psel` change, or a new accumulator value, reaches `phase_out` right after the edge that registers it.

The bench drives its inputs on the falling edge. It keeps an arithmetic model of the accumulator, the registers and the select registers, and updates that model on the rising edge from the same pre-edge values. It compares `phase_out` on every falling edge, before the next input change. Each of these latencies is therefore checked in the exact cycle where it applies, including frequency hops, writes to the live register, ignored addresses and accumulator wrap.

// File: rtl/dds_mod_pkg.sv
package dds_mod_pkg;
   // Width of a select that indexes n entries (at least one bit).
   function automatic int sel_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/dds_reg_bank.sv
module dds_reg_bank #(
   parameter int WORD_W = 12,
   parameter int N_WORDS = 4,
   parameter int BASE = 0,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 28
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [N_WORDS-1:0][WORD_W-1:0] words
);
   if (WORD_W > DATA_W) begin : g_bad_w
      $error("dds_reg_bank: WORD_W exceeds DATA_W");
   end
   if (BASE + N_WORDS > (1 << ADDR_W)) begin : g_bad_a
      $error("dds_reg_bank: address range exceeds ADDR_W");
   end

   for (genvar i = 0; i < N_WORDS; i++) begin : g_word
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + i);
      always_ff @(posedge clk) begin
         if (rst)
            words[i] <= '0;
         else if (wr_en && (wr_addr == MY_ADDR))
            words[i] <= wr_data[WORD_W-1:0];
      end
   end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int ACC_W = 28
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] step,
   output logic [ACC_W-1:0] acc
);
   always_ff @(posedge clk) begin
      if (rst)
         acc <= '0;
      else
         acc <= acc + step;
   end
endmodule

// File: rtl/dds_offset_add.sv
module dds_offset_add #(
   parameter int PHASE_W = 12,
   parameter bit REGISTER_OUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PHASE_W-1:0] coarse,
   input  logic [PHASE_W-1:0] offset,
   output logic [PHASE_W-1:0] phase
);
   logic [PHASE_W-1:0] sum;
   assign sum = coarse + offset;

   if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst)
            phase <= '0;
         else
            phase <= sum;
      end
   end else begin : g_comb
      assign phase = sum;
   end
endmodule

// File: rtl/dds_keying_mod.sv
module dds_keying_mod import dds_mod_pkg::*; #(
   parameter int FREQ_W = 28,
   parameter int PHASE_W = 12,
   parameter int N_FREQ = 2,
   parameter int N_PHASE = 4,
   parameter int ADDR_W = 3,
   parameter bit REGISTER_OUT = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [FREQ_W-1:0]          wr_data,
   input  logic [sel_w(N_FREQ)-1:0]   fsel,
   input  logic [sel_w(N_PHASE)-1:0]  psel,
   output logic [PHASE_W-1:0]         phase_out
);
   localparam int FSEL_W = sel_w(N_FREQ);
   localparam int PSEL_W = sel_w(N_PHASE);
   localparam int PHASE_BASE = N_FREQ;

   if (PHASE_W > FREQ_W) begin : g_bad_phase
      $error("dds_keying_mod: PHASE_W must not exceed FREQ_W");
   end
   if (N_FREQ + N_PHASE > (1 << ADDR_W)) begin : g_bad_map
      $error("dds_keying_mod: register map does not fit ADDR_W");
   end

   logic [N_FREQ-1:0][FREQ_W-1:0]   freq_words;
   logic [N_PHASE-1:0][PHASE_W-1:0] phase_words;
   logic [FSEL_W-1:0]               fsel_q;
   logic [PSEL_W-1:0]               psel_q;
   logic [FREQ_W-1:0]               acc;
   logic [FREQ_W-1:0]               step;
   logic [PHASE_W-1:0]              offset;

   dds_reg_bank #(
      .WORD_W(FREQ_W), .N_WORDS(N_FREQ), .BASE(0),
      .ADDR_W(ADDR_W), .DATA_W(FREQ_W)
   ) u_fbank (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .words(freq_words)
   );

   dds_reg_bank #(
      .WORD_W(PHASE_W), .N_WORDS(N_PHASE), .BASE(PHASE_BASE),
      .ADDR_W(ADDR_W), .DATA_W(FREQ_W)
   ) u_pbank (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .words(phase_words)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         fsel_q <= '0;
         psel_q <= '0;
      end else begin
         fsel_q <= fsel;
         psel_q <= psel;
      end
   end

   assign step   = freq_words[fsel_q];
   assign offset = phase_words[psel_q];

   dds_phase_acc #(.ACC_W(FREQ_W)) u_acc (
      .clk(clk), .rst(rst), .step(step), .acc(acc)
   );

   dds_offset_add #(.PHASE_W(PHASE_W), .REGISTER_OUT(REGISTER_OUT)) u_add (
      .clk(clk), .rst(rst), .coarse(acc[FREQ_W-1 -: PHASE_W]),
      .offset(offset), .phase(phase_out)
   );
endmodule

// File: rtl/dds_keying_mod_chk.sv
module dds_keying_mod_chk #(
   parameter int FREQ_W = 28,
   parameter int PHASE_W = 12,
   parameter int N_FREQ = 2,
   parameter int N_PHASE = 4,
   parameter int ADDR_W = 3,
   parameter int FSEL_W = 1
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       wr_en,
   input logic [ADDR_W-1:0]          wr_addr,
   input logic [FREQ_W-1:0]          wr_data,
   input logic [FSEL_W-1:0]          fsel,
   input logic [FSEL_W-1:0]          fsel_q,
   input logic [N_FREQ-1:0][FREQ_W-1:0]   freq_words,
   input logic [N_PHASE-1:0][PHASE_W-1:0] phase_words,
   input logic [PHASE_W-1:0]         phase_out
);
   assert_reset_zero_R1: assert property (@(posedge clk)
      rst |=> (phase_out == '0));

   assert_unmapped_ignored_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (int'(wr_addr) >= N_FREQ + N_PHASE))
         |=> ($stable(freq_words) && $stable(phase_words)));

   assert_fsel_registered_R5: assert property (@(posedge clk) disable iff (rst)
      !$stable(fsel) |=> (fsel_q == $past(fsel)));

   for (genvar i = 0; i < N_FREQ; i++) begin : g_fw
      assert_freq_write_R2: assert property (@(posedge clk) disable iff (rst)
         (wr_en && (wr_addr == ADDR_W'(i))) |=> (freq_words[i] == $past(wr_data)));
   end
   for (genvar i = 0; i < N_PHASE; i++) begin : g_pw
      assert_phase_write_R2: assert property (@(posedge clk) disable iff (rst)
         (wr_en && (wr_addr == ADDR_W'(N_FREQ + i)))
            |=> (phase_words[i] == $past(wr_data[PHASE_W-1:0])));
   end
endmodule

bind dds_keying_mod dds_keying_mod_chk #(
   .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .N_FREQ(N_FREQ),
   .N_PHASE(N_PHASE), .ADDR_W(ADDR_W), .FSEL_W(FSEL_W)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .fsel(fsel), .fsel_q(fsel_q),
   .freq_words(freq_words), .phase_words(phase_words),
   .phase_out(phase_out)
);

// File: tb/dds_keying_mod_tb.sv
module dds_keying_mod_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [27:0] wr_data = '0;
   logic        fsel = 1'b0;
   logic [1:0]  psel = '0;
   logic [11:0] phase_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Reference state, built from the requirements
   logic [27:0] m_f [2];
   logic [11:0] m_p [4];
   logic [27:0] m_acc;
   logic        m_fq;
   logic [1:0]  m_pq;

   always #5 clk = ~clk;

   dds_keying_mod u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .fsel(fsel), .psel(psel), .phase_out(phase_out)
   );

   always @(posedge clk) begin
      if (rst) begin
         m_acc <= '0; m_fq <= 1'b0; m_pq <= '0;
         m_f[0] <= '0; m_f[1] <= '0;
         for (int i = 0; i < 4; i++) m_p[i] <= '0;
      end else begin
         m_acc <= m_acc + m_f[m_fq];           // R4
         m_fq  <= fsel;                       // R5
         m_pq  <= psel;
         if (wr_en && wr_addr < 3'd2) m_f[wr_addr[0]] <= wr_data;              // R2
         else if (wr_en && wr_addr < 3'd6) m_p[wr_addr - 3'd2] <= wr_data[11:0];
      end
   end

   task automatic tick(input string tag);
      logic [11:0] exp;
      @(negedge clk);
      exp = m_acc[27:16] + m_p[m_pq];         // R7
      n_cmp++;
      if (phase_out !== exp) begin
         n_bad++;
         $display("FAIL %s: phase_out=%h expected=%h", tag, phase_out, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [27:0] d, input string tag);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick(tag);
      wr_en = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      tick("R1 reset");
      rst = 1'b0;
      tick("R1 after reset");
      // R2 load all registers; R9 quadrature offsets
      wr(3'd0, 28'h0123457, "R2");
      wr(3'd1, 28'h0A00001, "R2");
      wr(3'd2, 28'h0000000, "R2");
      wr(3'd3, 28'hFFFF400, "R2");
      wr(3'd4, 28'h0000C00, "R2");
      wr(3'd5, 28'h0000800, "R2");
      repeat (40) tick("R4 steady mark");
      // R6/R5 frequency hops keep phase
      for (int k = 0; k < 14; k++) begin
         fsel = ~fsel;
         repeat (3) tick("R6 hop");
      end
      fsel = 1'b1; tick("R5 select edge1"); tick("R5 select edge2");
      fsel = 1'b0; tick("R5 select edge1"); tick("R5 select edge2");
      // R7 every select combination
      for (int f = 0; f < 2; f++)
         for (int p = 0; p < 4; p++) begin
            fsel = f[0]; psel = p[1:0];
            repeat (6) tick("R7 select sweep");
         end
      // R8 write to the live word
      fsel = 1'b0; psel = 2'd0;
      repeat (3) tick("R8 pre");
      wr(3'd0, 28'h0033333, "R8 live write");
      repeat (10) tick("R8 post");
      // R9 frozen accumulator: output shows only the offsets
      wr(3'd0, 28'h0000000, "R9 stop");
      for (int p = 0; p < 4; p++) begin
         psel = p[1:0];
         repeat (3) tick("R9 offset only");
      end
      // R3 unmapped addresses
      wr(3'd6, 28'hABCDEF1, "R3 addr6");
      wr(3'd7, 28'h5555555, "R3 addr7");
      for (int f = 0; f < 2; f++)
         for (int p = 0; p < 4; p++) begin
            fsel = f[0]; psel = p[1:0];
            repeat (3) tick("R3 banks intact");
         end
      // R4 wrap with near-full step
      wr(3'd1, 28'hFFFFFF0, "R4 big step");
      fsel = 1'b1; psel = 2'd3;
      repeat (30) tick("R4 wrap");
      // R1 reset mid-run
      rst = 1'b1;
      tick("R1 mid reset"); tick("R1 mid reset");
      rst = 1'b0;
      repeat (5) tick("R1 restart");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule